// File: doc/BRIEF.md
# Sampler Hit-Count Averaging Unit

This unit averages the one-bit outcomes of a comparator-style sampler at a single test point. A test point is one threshold setting and one clock phase. After a start, the unit counts every valid sample strobe in one window and, separately, the strobes on which the sampler decided high. When the window length is reached it stops and raises a done flag. The two counts then stay on its outputs for readout, and the ratio of the counts gives the probability that the sampler decides high at that threshold.

An acquisition repeats the window at each threshold step for a fixed phase. The resulting sequence of ratios traces the cumulative distribution of the sampled voltage. The sampler can also be pointed at an external calibration voltage to measure its offset. A mode bit given with start is kept in a status flag, so offset runs can be told apart from measurement runs. Averaging many strobes suppresses jitter and dynamic offset noise, so each strobe inside the window is counted exactly once.

Top module: `hitavg_top`

## Requirements
- R1: After reset, both counts are zero, busy and done are low, and the calibration flag is low.
- R2: A start pulse while not busy zeroes both counts, latches the window length and the calibration bit, and raises busy on the following cycle.
- R3: While busy, each cycle with the strobe high adds exactly one to the total count, and adds one to the hit count only when the decision bit is 1.
- R4: The strobe that brings the total count to the window length drops busy and raises done in that same update. The counts then hold. A window length of 1 completes on the first strobe.
- R5: Strobes and decisions arriving while idle or done have no effect on either count.
- R6: A start pulse while busy is ignored: counting continues, and the window length and calibration flag keep their latched values.
- R7: A window length of 0 at start selects the default window length parameter, which is 1,000,000 by default.
- R8: Clear returns the unit to idle and zeroes both counts, done and the calibration flag. Clear takes precedence over a start in the same cycle.
- R9: The calibration flag keeps the value sampled at an accepted start through the run and the done state, whatever the mode input does afterwards.
- R10: The hit count never exceeds the total count, and a counter at its all-ones value saturates instead of wrapping.
- R11: A start while done begins a new window from zero counts with a newly latched length and calibration bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a new window (ignored while busy) |
| clear_i | input | 1 | Abort to idle and zero the counts |
| strobe_i | input | 1 | One valid sampler decision this cycle |
| decision_i | input | 1 | Sampler outcome, 1 = resolved high |
| cal_mode_i | input | 1 | Run is an offset calibration, latched at start |
| win_len_i | input | CNT_W | Window length in strobes, 0 selects DEF_LEN |
| total_o | output | CNT_W | Strobes counted in the current window |
| hits_o | output | CNT_W | Strobes that decided high |
| busy_o | output | 1 | Window in progress |
| done_o | output | 1 | Window complete, counts valid |
| cal_flag_o | output | 1 | Calibration bit of the current or last run |

## Verification
On every cycle the assertions check the following: hit count never exceeds total count, busy and done are never high together, the total stays below the latched length while busy, the counts stay frozen outside a window, a busy strobe advances the total by exactly one, the calibration flag stays fixed during a run, and a saturated counter stays saturated. Some behaviours can only be shown by the bench scenarios. These are the exact hit counts for specific decision patterns, completion on precisely the programmed strobe, the default length chosen by a zero window, the start ignored mid-run, the precedence of clear, and the restart from done.

// File: rtl/hitavg_pkg.sv
package hitavg_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_RUN  = 2'd1,
    PH_DONE = 2'd2
  } phase_t;

  localparam int unsigned NUM_CNT = 2;
  localparam int unsigned IDX_TOTAL = 0;
  localparam int unsigned IDX_HITS  = 1;
endpackage

// File: rtl/hitavg_satcnt.sv
module hitavg_satcnt #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;

  // R10: a full counter never wraps to zero on increment
  a_r10_sat_hold: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_MAX && !clr_i) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/hitavg_ctrl.sv
module hitavg_ctrl
  import hitavg_pkg::*;
#(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned DEF_LEN = 1000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             strobe_i,
  input  logic             cal_mode_i,
  input  logic [CNT_W-1:0] win_len_i,
  input  logic [CNT_W-1:0] total_i,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             cal_flag_o
);
  localparam logic [CNT_W-1:0] DEF_V = CNT_W'(DEF_LEN);

  phase_t           state_q;
  logic [CNT_W-1:0] len_q;
  logic             cal_q;
  logic             accept_start;
  logic             last_strobe;

  assign accept_start = start_i && !clear_i && (state_q != PH_RUN);
  assign cnt_en_o     = strobe_i && !clear_i && (state_q == PH_RUN);
  assign cnt_clr_o    = clear_i || accept_start;
  assign last_strobe  = cnt_en_o && (total_i == (len_q - 1'b1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_IDLE;
      len_q   <= DEF_V;
      cal_q   <= 1'b0;
    end else if (clear_i) begin
      state_q <= PH_IDLE;
      cal_q   <= 1'b0;
    end else if (accept_start) begin
      state_q <= PH_RUN;
      len_q   <= (win_len_i == '0) ? DEF_V : win_len_i;
      cal_q   <= cal_mode_i;
    end else if (last_strobe) begin
      state_q <= PH_DONE;
    end
  end

  assign busy_o     = (state_q == PH_RUN);
  assign done_o     = (state_q == PH_DONE);
  assign cal_flag_o = cal_q;

  // R4: the running total stays short of the latched window length
  a_r4_total_in_window: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (total_i < len_q));

  // R6: a start during a run leaves the latched length untouched
  a_r6_len_kept: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i && !clear_i) |=> (len_q == $past(len_q)));
endmodule

// File: rtl/hitavg_top.sv
module hitavg_top
  import hitavg_pkg::*;
#(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned DEF_LEN = 1000000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic             strobe_i,
  input  logic             decision_i,
  input  logic             cal_mode_i,
  input  logic [CNT_W-1:0] win_len_i,
  output logic [CNT_W-1:0] total_o,
  output logic [CNT_W-1:0] hits_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             cal_flag_o
);
  logic             cnt_clr;
  logic             cnt_en;
  logic [NUM_CNT-1:0] inc_v;
  logic [CNT_W-1:0] cnt_v [NUM_CNT];

  hitavg_ctrl #(
    .CNT_W   (CNT_W),
    .DEF_LEN (DEF_LEN)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .clear_i    (clear_i),
    .strobe_i   (strobe_i),
    .cal_mode_i (cal_mode_i),
    .win_len_i  (win_len_i),
    .total_i    (cnt_v[IDX_TOTAL]),
    .cnt_clr_o  (cnt_clr),
    .cnt_en_o   (cnt_en),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .cal_flag_o (cal_flag_o)
  );

  assign inc_v[IDX_TOTAL] = cnt_en;
  assign inc_v[IDX_HITS]  = cnt_en && decision_i;

  for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
    hitavg_satcnt #(
      .CNT_W (CNT_W)
    ) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr_i (cnt_clr),
      .inc_i (inc_v[k]),
      .cnt_o (cnt_v[k])
    );
  end

  assign total_o = cnt_v[IDX_TOTAL];
  assign hits_o  = cnt_v[IDX_HITS];

  // R10: hits are a subset of counted strobes
  a_r10_hits_le_total: assert property (@(posedge clk) disable iff (rst)
    hits_o <= total_o);

  // R4: running and finished are exclusive
  a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o));

  // R3: an accepted strobe advances the total by exactly one
  a_r3_total_step: assert property (@(posedge clk) disable iff (rst)
    (busy_o && strobe_i && !clear_i) |=> (total_o == $past(total_o) + 1'b1));

  // R5: outside a window the counts are frozen unless cleared or restarted
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start_i && !clear_i) |=> ($stable(total_o) && $stable(hits_o)));

  // R9: the calibration flag cannot change during a run except by clear
  a_r9_cal_stable: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !clear_i) |=> $stable(cal_flag_o));
endmodule

// File: tb/hitavg_top_test.sv
module hitavg_top_test;
  localparam int unsigned W   = 20;
  localparam int unsigned DEF = 40;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0, clear_i = 1'b0, strobe_i = 1'b0;
  logic         decision_i = 1'b0, cal_mode_i = 1'b0;
  logic [W-1:0] win_len_i = '0;
  logic [W-1:0] total_o, hits_o;
  logic         busy_o, done_o, cal_flag_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  int m_total = 0, m_hits = 0, m_len = 0;
  bit m_busy = 0, m_done = 0, m_cal = 0;

  always #4 clk = ~clk;

  hitavg_top #(.CNT_W(W), .DEF_LEN(DEF)) uut (
    .clk(clk), .rst(rst), .start_i(start_i), .clear_i(clear_i),
    .strobe_i(strobe_i), .decision_i(decision_i), .cal_mode_i(cal_mode_i),
    .win_len_i(win_len_i), .total_o(total_o), .hits_o(hits_o),
    .busy_o(busy_o), .done_o(done_o), .cal_flag_o(cal_flag_o)
  );

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_all(string req);
    chk({req, " total"}, int'(total_o), m_total);
    chk({req, " hits"}, int'(hits_o), m_hits);
    chk({req, " busy"}, int'(busy_o), int'(m_busy));
    chk({req, " done"}, int'(done_o), int'(m_done));
    chk({req, " cal"}, int'(cal_flag_o), int'(m_cal));
    chk({req, " R10 hits<=total"}, int'(hits_o <= total_o), 1);
  endtask

  function automatic bit dec_of(int mode, int i);
    case (mode)
      0: return 1'b1;
      1: return 1'b0;
      2: return (i % 2) == 0;
      default: return (i % 3) == 0;
    endcase
  endfunction

  task automatic do_start(int len, bit cal);
    start_i = 1'b1; win_len_i = W'(len); cal_mode_i = cal;
    @(negedge clk);
    start_i = 1'b0; win_len_i = '0;
    if (!m_busy) begin
      m_busy = 1; m_done = 0; m_total = 0; m_hits = 0;
      m_len = (len == 0) ? DEF : len; m_cal = cal;
    end
  endtask

  task automatic do_clear(bit with_start);
    clear_i = 1'b1; start_i = with_start; win_len_i = W'(5);
    @(negedge clk);
    clear_i = 1'b0; start_i = 1'b0; win_len_i = '0;
    m_busy = 0; m_done = 0; m_total = 0; m_hits = 0; m_cal = 0;
  endtask

  task automatic feed(int n, int gap, int mode);
    for (int i = 0; i < n; i++) begin
      strobe_i = 1'b1; decision_i = dec_of(mode, i);
      @(negedge clk);
      if (m_busy) begin
        m_total++;
        if (dec_of(mode, i)) m_hits++;
        if (m_total == m_len) begin m_busy = 0; m_done = 1; end
      end
      strobe_i = 1'b0; decision_i = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk_all("R1 reset");
  endtask

  task automatic t_basic();
    do_start(10, 0);
    chk_all("R2 start");
    feed(4, 0, 2);
    chk_all("R3 mid-run alternating");
    feed(8, 0, 2);
    chk_all("R4 done at length, R5 extra strobes ignored");
    chk("R4 hits of alternating window", int'(hits_o), 5);
  endtask

  task automatic t_gaps();
    do_start(7, 0);
    feed(7, 2, 3);
    chk_all("R3 gapped strobes");
    chk("R3 hits every third", int'(hits_o), 3);
    cal_mode_i = 1'b1;
    repeat (3) @(negedge clk);
    cal_mode_i = 1'b0;
    chk_all("R5 hold in done");
  endtask

  task automatic t_idle_ignore();
    do_clear(0);
    feed(5, 0, 0);
    chk_all("R5 strobes while idle");
  endtask

  task automatic t_start_busy();
    do_start(8, 0);
    feed(3, 0, 0);
    do_start(3, 1);
    chk_all("R6 start while busy ignored");
    feed(1, 0, 1);
    chk_all("R6 length kept after ignored start");
    feed(4, 0, 1);
    chk_all("R6 finish at original length");
    chk("R6 total equals 8", int'(total_o), 8);
  endtask

  task automatic t_default();
    do_start(0, 0);
    feed(DEF - 1, 0, 0);
    chk_all("R7 default window one short");
    feed(3, 0, 0);
    chk_all("R7 default window complete");
    chk("R7 total equals default", int'(total_o), DEF);
  endtask

  task automatic t_clear();
    do_start(20, 1);
    feed(6, 0, 2);
    do_clear(0);
    chk_all("R8 clear mid-run");
    do_clear(1);
    chk_all("R8 clear wins over start");
  endtask

  task automatic t_cal_restart();
    do_start(5, 1);
    cal_mode_i = 1'b0;
    feed(5, 1, 0);
    chk_all("R9 cal flag held through run");
    do_start(4, 0);
    chk_all("R11 restart from done");
    feed(4, 0, 3);
    chk_all("R11 second window complete");
  endtask

  task automatic t_len1();
    do_start(1, 0);
    feed(1, 0, 0);
    chk_all("R4 length one window");
    chk("R4 length one done", int'(done_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_gaps();
    t_idle_ignore();
    t_start_busy();
    t_default();
    t_clear();
    t_cal_restart();
    t_len1();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule